// File: doc/BRIEF.md
# AXI4-Lite Single-Register Bridge

This block converts an AXI4-Lite slave port into a one-register peripheral interface. On the peripheral side there is a strobe, a write-enable, write data, per-byte selects and a combinational read-data input. The peripheral never stalls and always answers in the cycle it is strobed. The bridge therefore keeps every AXI ready signal high. It turns each accepted request into a single peripheral strobe and returns the matching response one clock later.

The upstream master must present the write address and the write data together. It must not issue a second request of a given kind while the response to the previous one is still waiting. The peripheral sits at a single address, so there are no address inputs and nothing is decoded. Read data is sampled from the peripheral in the accepting cycle. It is held in a register until the master takes the response. Every response carries the OKAY code.

Top module: `axil_single_reg_bridge`

## Requirements
- R1: axiAwReady, axiWReady and axiArReady are 1 in every cycle, including during reset.
- R2: In a cycle where axiAwValid and axiWValid are both 1, periphStb and periphWe are 1 and periphWdata equals axiWData in that same cycle.
- R3: axiBValid is 1 in the clock cycle after a write is accepted.
- R4: In a cycle where axiArValid is 1, periphStb is 1. The bridge samples periphRdata in that cycle, and in the following cycle axiRValid is 1 with axiRData equal to the sampled value. periphWe is 0 when only a read is present.
- R5: periphSel equals axiWStrb unchanged, where bit k selects byte k (bits 8k+7 down to 8k) of the register.
- R6: axiBResp and axiRResp are always 2'b00 (OKAY).
- R7: While axiBValid is 1 and axiBReady is 0, axiBValid stays 1. It falls in the cycle after axiBReady is 1.
- R8: While axiRValid is 1 and axiRReady is 0, axiRValid stays 1 and axiRData holds its value, even if periphRdata changes.
- R9: When a read and a write arrive in the same cycle, one strobe with periphWe = 1 is issued. The read returns the register value from before that write, and both axiBValid and axiRValid are 1 in the next cycle.
- R10: periphStb is 0 in a cycle with no request.
- R11: A synchronous reset (rstN = 0 at a clock edge) clears axiBValid and axiRValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| axiAwValid | input | 1 | Write address valid |
| axiAwReady | output | 1 | Write address ready (constant 1) |
| axiWValid | input | 1 | Write data valid |
| axiWReady | output | 1 | Write data ready (constant 1) |
| axiWData | input | DATA_W | Write data |
| axiWStrb | input | DATA_W/8 | Write byte strobes |
| axiBValid | output | 1 | Write response valid |
| axiBReady | input | 1 | Write response ready |
| axiBResp | output | 2 | Write response code |
| axiArValid | input | 1 | Read address valid |
| axiArReady | output | 1 | Read address ready (constant 1) |
| axiRValid | output | 1 | Read response valid |
| axiRReady | input | 1 | Read response ready |
| axiRData | output | DATA_W | Read data |
| axiRResp | output | 2 | Read response code |
| periphStb | output | 1 | Peripheral access strobe |
| periphWe | output | 1 | Peripheral write enable |
| periphWdata | output | DATA_W | Peripheral write data |
| periphSel | output | DATA_W/8 | Peripheral byte selects |
| periphRdata | input | DATA_W | Peripheral combinational read data |

## Verification
A read request and a write request can land on the same clock edge and share the single peripheral strobe. The bench provokes this by raising axiArValid together with the write pair while the bench's stand-in register holds a known old value. It then judges that the write is applied with periphWe = 1, that the read response carries the old value, and that both responses appear in the next cycle. The same collision is repeated with both response readies held low and a reset applied, to show that reset clears both pending responses.

// File: rtl/axil_bridge_pkg.sv
package axil_bridge_pkg;

  // Strobes from the control path to the datapath, one per accepted request kind
  typedef struct packed {
    logic wrFire;
    logic rdFire;
  } reqStrobes_t;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/axil_bridge_ctrl.sv
module axil_bridge_ctrl
  import axil_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        awValid,
  input  logic        wValid,
  input  logic        arValid,
  input  logic        bReady,
  input  logic        rReady,
  output reqStrobes_t strobes,
  output logic        bValid,
  output logic        rValid,
  output logic        periphStb,
  output logic        periphWe
);

  logic bValidQ;
  logic rValidQ;

  // Address and data are presented together by contract; both must be high
  always_comb begin
    strobes.wrFire = awValid & wValid;
    strobes.rdFire = arValid;
  end

  // A write wins the shared write-enable; a concurrent read samples the old value
  assign periphStb = strobes.wrFire | strobes.rdFire;
  assign periphWe  = strobes.wrFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValidQ <= 1'b0;
    end else if (strobes.wrFire) begin
      bValidQ <= 1'b1;
    end else if (bReady) begin
      bValidQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValidQ <= 1'b0;
    end else if (strobes.rdFire) begin
      rValidQ <= 1'b1;
    end else if (rReady) begin
      rValidQ <= 1'b0;
    end
  end

  assign bValid = bValidQ;
  assign rValid = rValidQ;

endmodule

// File: rtl/axil_bridge_datapath.sv
module axil_bridge_datapath
  import axil_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  reqStrobes_t       strobes,
  input  logic [DATA_W-1:0] wData,
  input  logic [STRB_W-1:0] wStrb,
  input  logic [DATA_W-1:0] periphRdata,
  output logic [DATA_W-1:0] periphWdata,
  output logic [STRB_W-1:0] periphSel,
  output logic [DATA_W-1:0] rData
);

  logic [DATA_W-1:0] rDataQ;

  assign periphWdata = wData;
  assign periphSel   = wStrb;

  // Capture on acceptance only, so the value holds through back-pressure
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rDataQ <= '0;
    end else if (strobes.rdFire) begin
      rDataQ <= periphRdata;
    end
  end

  assign rData = rDataQ;

endmodule

// File: rtl/axil_single_reg_bridge.sv
module axil_single_reg_bridge
  import axil_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              axiAwValid,
  output logic              axiAwReady,
  input  logic              axiWValid,
  output logic              axiWReady,
  input  logic [DATA_W-1:0] axiWData,
  input  logic [STRB_W-1:0] axiWStrb,
  output logic              axiBValid,
  input  logic              axiBReady,
  output logic [1:0]        axiBResp,
  input  logic              axiArValid,
  output logic              axiArReady,
  output logic              axiRValid,
  input  logic              axiRReady,
  output logic [DATA_W-1:0] axiRData,
  output logic [1:0]        axiRResp,
  output logic              periphStb,
  output logic              periphWe,
  output logic [DATA_W-1:0] periphWdata,
  output logic [STRB_W-1:0] periphSel,
  input  logic [DATA_W-1:0] periphRdata
);

  reqStrobes_t strobes;

  assign axiAwReady = 1'b1;
  assign axiWReady  = 1'b1;
  assign axiArReady = 1'b1;
  assign axiBResp   = RESP_OKAY;
  assign axiRResp   = RESP_OKAY;

  axil_bridge_ctrl ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .awValid   (axiAwValid),
    .wValid    (axiWValid),
    .arValid   (axiArValid),
    .bReady    (axiBReady),
    .rReady    (axiRReady),
    .strobes   (strobes),
    .bValid    (axiBValid),
    .rValid    (axiRValid),
    .periphStb (periphStb),
    .periphWe  (periphWe)
  );

  axil_bridge_datapath #(.DATA_W(DATA_W)) dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wData       (axiWData),
    .wStrb       (axiWStrb),
    .periphRdata (periphRdata),
    .periphWdata (periphWdata),
    .periphSel   (periphSel),
    .rData       (axiRData)
  );

endmodule

// File: rtl/axil_bridge_checker.sv
module axil_bridge_checker #(
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              axiAwValid,
  input logic              axiAwReady,
  input logic              axiWValid,
  input logic              axiWReady,
  input logic [STRB_W-1:0] axiWStrb,
  input logic              axiBValid,
  input logic              axiBReady,
  input logic [1:0]        axiBResp,
  input logic              axiArValid,
  input logic              axiArReady,
  input logic              axiRValid,
  input logic              axiRReady,
  input logic [DATA_W-1:0] axiRData,
  input logic [1:0]        axiRResp,
  input logic              periphStb,
  input logic              periphWe,
  input logic [STRB_W-1:0] periphSel
);

  assert_ready_high_R1: assert property (@(posedge clk)
    axiAwReady && axiWReady && axiArReady);

  assert_write_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (axiAwValid && axiWValid) |-> (periphStb && periphWe));

  assert_bvalid_next_R3: assert property (@(posedge clk) disable iff (!rstN)
    (axiAwValid && axiWValid) |=> axiBValid);

  assert_rvalid_next_R4: assert property (@(posedge clk) disable iff (!rstN)
    axiArValid |=> axiRValid);

  assert_sel_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (axiAwValid && axiWValid) |-> (periphSel == axiWStrb));

  assert_resp_okay_R6: assert property (@(posedge clk) disable iff (!rstN)
    (axiBResp == 2'b00) && (axiRResp == 2'b00));

  assert_bhold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (axiBValid && !axiBReady) |=> axiBValid);

  assert_rhold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (axiRValid && !axiRReady && !axiArValid) |=> (axiRValid && $stable(axiRData)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!axiArValid && !(axiAwValid && axiWValid)) |-> !periphStb);

endmodule

bind axil_single_reg_bridge axil_bridge_checker #(.DATA_W(DATA_W)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .axiAwValid (axiAwValid),
  .axiAwReady (axiAwReady),
  .axiWValid  (axiWValid),
  .axiWReady  (axiWReady),
  .axiWStrb   (axiWStrb),
  .axiBValid  (axiBValid),
  .axiBReady  (axiBReady),
  .axiBResp   (axiBResp),
  .axiArValid (axiArValid),
  .axiArReady (axiArReady),
  .axiRValid  (axiRValid),
  .axiRReady  (axiRReady),
  .axiRData   (axiRData),
  .axiRResp   (axiRResp),
  .periphStb  (periphStb),
  .periphWe   (periphWe),
  .periphSel  (periphSel)
);

// File: tb/axil_single_reg_bridge_test.sv
module axil_single_reg_bridge_test;

  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              axiAwValid, axiWValid, axiArValid;
  logic              axiAwReady, axiWReady, axiArReady;
  logic [DATA_W-1:0] axiWData;
  logic [STRB_W-1:0] axiWStrb;
  logic              axiBValid, axiBReady, axiRValid, axiRReady;
  logic [1:0]        axiBResp, axiRResp;
  logic [DATA_W-1:0] axiRData;
  logic              periphStb, periphWe;
  logic [DATA_W-1:0] periphWdata, periphRdata;
  logic [STRB_W-1:0] periphSel;

  logic [DATA_W-1:0] modelReg;
  logic [DATA_W-1:0] expReg;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  axil_single_reg_bridge #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN),
    .axiAwValid(axiAwValid), .axiAwReady(axiAwReady),
    .axiWValid(axiWValid), .axiWReady(axiWReady),
    .axiWData(axiWData), .axiWStrb(axiWStrb),
    .axiBValid(axiBValid), .axiBReady(axiBReady), .axiBResp(axiBResp),
    .axiArValid(axiArValid), .axiArReady(axiArReady),
    .axiRValid(axiRValid), .axiRReady(axiRReady),
    .axiRData(axiRData), .axiRResp(axiRResp),
    .periphStb(periphStb), .periphWe(periphWe),
    .periphWdata(periphWdata), .periphSel(periphSel),
    .periphRdata(periphRdata)
  );

  // Stand-in peripheral: one register with byte selects, combinational read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modelReg <= '0;
    end else if (periphStb && periphWe) begin
      for (int k = 0; k < STRB_W; k++) begin
        if (periphSel[k]) modelReg[8*k +: 8] <= periphWdata[8*k +: 8];
      end
    end
  end
  assign periphRdata = modelReg;

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
      input logic [DATA_W-1:0] d, input logic [STRB_W-1:0] s);
    logic [DATA_W-1:0] r = old;
    for (int k = 0; k < STRB_W; k++) if (s[k]) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    step();
    step();
    check("R11 bValid after reset", {31'b0, axiBValid}, 0);
    check("R11 rValid after reset", {31'b0, axiRValid}, 0);
    check("R1 readies in reset", {29'b0, axiAwReady, axiWReady, axiArReady}, 3'b111);
    rstN = 1'b1;
    expReg = '0;
    step();
  endtask

  task automatic testWrite(input logic [DATA_W-1:0] d, input logic [STRB_W-1:0] s);
    axiAwValid = 1'b1; axiWValid = 1'b1; axiWData = d; axiWStrb = s;
    #1;
    check("R2 write strobe/we", {30'b0, periphStb, periphWe}, 2'b11);
    check("R2 write data", periphWdata, d);
    check("R5 byte select", {28'b0, periphSel}, {28'b0, s});
    check("R1 readies", {29'b0, axiAwReady, axiWReady, axiArReady}, 3'b111);
    step();
    axiAwValid = 1'b0; axiWValid = 1'b0;
    expReg = merge(expReg, d, s);
    check("R3 bValid next cycle", {31'b0, axiBValid}, 1);
    check("R6 bResp okay", {30'b0, axiBResp}, 0);
    step();
    check("R7 bValid drops with bReady", {31'b0, axiBValid}, 0);
  endtask

  task automatic testRead();
    axiArValid = 1'b1;
    #1;
    check("R4 read strobe/we", {30'b0, periphStb, periphWe}, 2'b10);
    step();
    axiArValid = 1'b0;
    check("R4 rValid next cycle", {31'b0, axiRValid}, 1);
    check("R4 rData", axiRData, expReg);
    check("R6 rResp okay", {30'b0, axiRResp}, 0);
    step();
    check("R8 rValid drops with rReady", {31'b0, axiRValid}, 0);
  endtask

  task automatic testIdle();
    #1;
    check("R10 no strobe when idle", {31'b0, periphStb}, 0);
    step();
    check("R10 no spurious responses", {30'b0, axiBValid, axiRValid}, 0);
  endtask

  task automatic testBackpressureB();
    axiBReady = 1'b0;
    axiAwValid = 1'b1; axiWValid = 1'b1; axiWData = 32'h1357_9BDF; axiWStrb = 4'hF;
    step();
    axiAwValid = 1'b0; axiWValid = 1'b0;
    expReg = 32'h1357_9BDF;
    for (int i = 0; i < 3; i++) begin
      check("R7 bValid held", {31'b0, axiBValid}, 1);
      step();
    end
    axiBReady = 1'b1;
    check("R7 bValid still held", {31'b0, axiBValid}, 1);
    step();
    check("R7 bValid released", {31'b0, axiBValid}, 0);
  endtask

  task automatic testBackpressureR();
    logic [DATA_W-1:0] oldVal;
    oldVal = expReg;
    axiRReady = 1'b0;
    axiArValid = 1'b1;
    step();
    axiArValid = 1'b0;
    // change the peripheral value while the read response waits
    axiAwValid = 1'b1; axiWValid = 1'b1; axiWData = 32'hCAFE_F00D; axiWStrb = 4'hF;
    step();
    axiAwValid = 1'b0; axiWValid = 1'b0;
    expReg = 32'hCAFE_F00D;
    step();
    check("R8 rValid held", {31'b0, axiRValid}, 1);
    check("R8 rData held", axiRData, oldVal);
    axiRReady = 1'b1;
    step();
    check("R8 rValid released", {31'b0, axiRValid}, 0);
    testRead();
  endtask

  task automatic testConcurrent();
    logic [DATA_W-1:0] oldVal;
    oldVal = expReg;
    axiArValid = 1'b1;
    axiAwValid = 1'b1; axiWValid = 1'b1; axiWData = 32'h0BAD_BEEF; axiWStrb = 4'hF;
    #1;
    check("R9 single strobe with we", {30'b0, periphStb, periphWe}, 2'b11);
    step();
    axiArValid = 1'b0; axiAwValid = 1'b0; axiWValid = 1'b0;
    expReg = 32'h0BAD_BEEF;
    check("R9 both responses", {30'b0, axiBValid, axiRValid}, 2'b11);
    check("R9 read returns old value", axiRData, oldVal);
    step();
    testRead();
  endtask

  task automatic testResetMid();
    axiBReady = 1'b0; axiRReady = 1'b0;
    axiArValid = 1'b1; axiAwValid = 1'b1; axiWValid = 1'b1;
    axiWData = 32'h5555_AAAA; axiWStrb = 4'hF;
    step();
    axiArValid = 1'b0; axiAwValid = 1'b0; axiWValid = 1'b0;
    check("R11 responses pending", {30'b0, axiBValid, axiRValid}, 2'b11);
    rstN = 1'b0;
    step();
    check("R11 reset clears responses", {30'b0, axiBValid, axiRValid}, 2'b00);
    rstN = 1'b1;
    axiBReady = 1'b1; axiRReady = 1'b1;
    expReg = '0;
    step();
  endtask

  initial begin
    rstN = 1'b0;
    axiAwValid = 1'b0; axiWValid = 1'b0; axiArValid = 1'b0;
    axiWData = '0; axiWStrb = '0;
    axiBReady = 1'b1; axiRReady = 1'b1;
    expReg = '0;
    @(negedge clk);
    doReset();
    testIdle();
    testWrite(32'h2345_8765, 4'hF);
    testRead();
    testWrite(32'hDEAD_BEEF, 4'b0101);
    testRead();
    testWrite(32'h0000_FF00, 4'b0010);
    testRead();
    testBackpressureB();
    testBackpressureR();
    testConcurrent();
    testResetMid();
    testRead();
    testIdle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule